// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the command side of a serial memory slave. It sits between an SPI bus (chip select, serial clock, data in, data out) and a 256K-byte memory that has a single-cycle synchronous byte port. It takes the first byte of each select period as a command. Memory commands are followed by a three-byte address, which the engine sends to the memory. Bytes then stream in or out one after another, and the address steps by one after each byte. There is no page buffer and no busy state: each received byte goes to the memory as soon as its eighth bit arrives.

The bus pins are sampled in the engine's own clock domain, which must run at least eight times faster than SCK. Whether a write may happen is decided outside the block. The engine holds the write-enable latch itself. A protection unit outside it answers two questions: whether the byte at the current memory address may be written, and whether the status byte may be replaced. That unit also supplies the status byte that the engine shifts out. The engine also handles a sleep command, and it returns an identification string that is set by a parameter.

Top module: `spi_mem_engine`

## Requirements
- R1: Only the first byte after a fall of `cs_n` is decoded as a command, MSB first. Command codes: 06h sets the latch, 04h clears it, 05h reads status, 01h writes status, 03h reads, 0Bh is a fast read, 02h writes, B9h requests sleep, 9Fh reads the ID. Any later byte in the same select period is never decoded as a command.
- R2: After 03h, 0Bh or 02h, the next three bytes form a 24-bit address, MSB first. Its upper 6 bits are ignored and the lower 18 bits select the byte.
- R3: A read drives each byte on `so` MSB first. Bits change on falling SCK edges, and `so_oe` is high while the bits are driven. Following bytes come from address+1, and the address wraps from 3FFFFh to 00000h.
- R4: A fast read first takes one dummy byte after the address. After that it returns the same data as a normal read.
- R5: A write byte produces exactly one `mem_we` pulse once its eighth bit is in. The pulse carries the byte's address, and the address then advances by one with the same wrap. A byte still incomplete when `cs_n` rises is dropped.
- R6: A write byte is committed only if `wel` is 1 and `mem_wr_ok` is 1 for its address. If a byte is refused, it and every later byte of the same burst are dropped.
- R7: `wel` is 0 after reset. Command 06h sets it and 04h clears it. It also clears when `cs_n` rises after a 01h or 02h command.
- R8: Command 05h shifts out `sr_rdata` MSB first, and repeats it for as long as clocks continue.
- R9: After 01h, the next full byte gives one `sr_wr_stb` pulse with that byte on `sr_wr_data`, but only when `wel` and `sr_wr_ok` are both 1. Further bytes are ignored.
- R10: Command 9Fh shifts out the `ID_VAL` parameter bytes, most significant byte first, and then 00h.
- R11: After an unknown command, `so_oe` stays low and nothing is written or changed until the next fall of `cs_n`.
- R12: Command B9h followed by a rise of `cs_n` sets `sleep`. The next fall of `cs_n` clears `sleep`, and the whole select period that follows is ignored.
- R13: `so_oe` is low whenever `cs_n` is high. Transfers that start with SCK idle low and transfers that start with SCK idle high give identical results.
- R14: The level on `si` has no effect while read data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| mem_wr_ok | input | 1 | Protection: current address writable |
| wel | output | 1 | Write-enable latch |
| sr_rdata | input | 8 | Status byte to shift out |
| sr_wr_ok | input | 1 | Protection: status write allowed |
| sr_wr_stb | output | 1 | Status write pulse |
| sr_wr_data | output | 8 | Status write value |
| sleep | output | 1 | Sleep state |

## Verification
The assertions check these properties on every cycle: `so_oe` stays off while the engine is deselected, write strobes are single pulses issued only with the latch set, each strobe is followed by a one-step address advance, and no output is active during sleep. Several behaviours can only be shown by the bench's bus scenarios. These are the byte order on `so`, the wrap at the top of the address space, the dummy-byte offset of fast read, the dropping of a partial byte, the stop of a burst at a protected address, the silence after an unknown command, the ignored wake-up transfer, and the equivalence of the two SCK idle levels.

// File: rtl/spi_mem_engine.sv
module spi_mem_engine #(
  parameter int ADDR_W = 18,
  parameter int ID_LEN = 9,
  parameter logic [ID_LEN*8-1:0] ID_VAL = 72'h3CA5_1122_3344_5566_77
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_wr_ok,
  output logic              wel,
  input  logic [7:0]        sr_rdata,
  input  logic              sr_wr_ok,
  output logic              sr_wr_stb,
  output logic [7:0]        sr_wr_data,
  output logic              sleep
);
  localparam int IDX_W = $clog2(ID_LEN + 1);
  localparam int ADDR_BYTES = 3;

  typedef enum logic [2:0] {S_OPC, S_ADR, S_DUM, S_RD, S_WR, S_SRW, S_OUT, S_DROP} st_t;

  st_t              st;
  logic             sck_q, cs_q;
  logic [2:0]       bcnt;
  logic [1:0]       acnt;
  logic [6:0]       sh;
  logic [7:0]       obyte, op;
  logic [ADDR_W-1:0] addr;
  logic             blk, clr_pend, sleep_arm, out_on, is_id;
  logic [IDX_W-1:0] idx;

  wire rise    = sck & ~sck_q & ~cs_n;
  wire fall    = ~sck & sck_q & ~cs_n;
  wire cs_fall = ~cs_n & cs_q;
  wire cs_rise = cs_n & ~cs_q;
  wire [7:0] inb = {sh, si};
  wire byte_done = rise && (bcnt == 3'd7) && (st != S_DROP);

  function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] i);
    logic [ID_LEN*8-1:0] t;
    t = ID_VAL << (8 * i);
    return t[ID_LEN*8-1 -: 8];
  endfunction

  wire [7:0] src = (st == S_RD) ? mem_rdata : (is_id ? id_byte(idx) : sr_rdata);

  assign mem_addr = addr;
  assign so       = obyte[7];
  assign so_oe    = out_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OPC; sck_q <= 1'b0; cs_q <= 1'b1; bcnt <= '0; acnt <= '0;
      sh <= '0; obyte <= '0; op <= '0; addr <= '0; blk <= 1'b0;
      clr_pend <= 1'b0; sleep_arm <= 1'b0; out_on <= 1'b0; is_id <= 1'b0;
      idx <= '0; wel <= 1'b0; sleep <= 1'b0; mem_we <= 1'b0; mem_wdata <= '0;
      sr_wr_stb <= 1'b0; sr_wr_data <= '0;
    end else begin
      sck_q <= sck;
      cs_q <= cs_n;
      mem_we <= 1'b0;
      sr_wr_stb <= 1'b0;
      if (mem_we) addr <= addr + 1'b1;
      if (cs_n) begin
        st <= S_OPC; bcnt <= '0; acnt <= '0; out_on <= 1'b0; blk <= 1'b0; idx <= '0;
        if (cs_rise && clr_pend) wel <= 1'b0;
        if (cs_rise && sleep_arm) sleep <= 1'b1;
        clr_pend <= 1'b0;
        sleep_arm <= 1'b0;
      end else if (cs_fall && sleep) begin
        sleep <= 1'b0;
        st <= S_DROP;
      end else begin
        if (rise && st != S_DROP) begin
          sh <= inb[6:0];
          bcnt <= bcnt + 1'b1;
        end
        if (byte_done) begin
          case (st)
            S_OPC: begin
              case (inb)
                8'h06: begin wel <= 1'b1; st <= S_DROP; end
                8'h04: begin wel <= 1'b0; st <= S_DROP; end
                8'h05: begin is_id <= 1'b0; st <= S_OUT; end
                8'h9F: begin is_id <= 1'b1; st <= S_OUT; end
                8'h01: begin clr_pend <= 1'b1; st <= S_SRW; end
                8'h03, 8'h0B: begin op <= inb; st <= S_ADR; end
                8'h02: begin op <= inb; clr_pend <= 1'b1; st <= S_ADR; end
                8'hB9: begin sleep_arm <= 1'b1; st <= S_DROP; end
                default: st <= S_DROP;
              endcase
            end
            S_ADR: begin
              addr <= {addr[ADDR_W-9:0], inb};
              acnt <= acnt + 1'b1;
              if (acnt == 2'(ADDR_BYTES - 1))
                st <= (op == 8'h02) ? S_WR : ((op == 8'h0B) ? S_DUM : S_RD);
            end
            S_DUM: st <= S_RD;
            S_WR: begin
              if (!blk && wel && mem_wr_ok) begin
                mem_we <= 1'b1;
                mem_wdata <= inb;
              end else begin
                blk <= 1'b1;
              end
            end
            S_SRW: begin
              if (wel && sr_wr_ok) begin
                sr_wr_stb <= 1'b1;
                sr_wr_data <= inb;
              end
              st <= S_DROP;
            end
            default: ;
          endcase
        end
        if (fall && (st == S_RD || st == S_OUT)) begin
          out_on <= 1'b1;
          if (bcnt == 3'd0) begin
            obyte <= src;
            if (st == S_RD) addr <= addr + 1'b1;
            if (st == S_OUT && is_id && idx != IDX_W'(ID_LEN)) idx <= idx + 1'b1;
          end else begin
            obyte <= {obyte[6:0], 1'b0};
          end
        end
      end
    end
  end

  AST_SO_QUIET_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !so_oe); // R13
  AST_WE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel); // R6
  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R5
  AST_SR_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_stb |-> wel); // R9
  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!so_oe && !mem_we && !sr_wr_stb)); // R12
endmodule

// File: tb/spi_mem_engine_tb.sv
module spi_mem_engine_tb_top;
  localparam int AW = 18;
  localparam int IDN = 9;
  localparam logic [IDN*8-1:0] IDV = 72'h7E81_0F2D_C3B4_9A01_66;
  localparam int H = 4;
  localparam int ASPACE = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, mem_we, mem_wr_ok, wel, sr_wr_ok, sr_wr_stb, sleep;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, sr_rdata, sr_wr_data;

  int errs = 0, checks = 0, we_cnt = 0, sr_cnt = 0, prot_lo = ASPACE;
  logic [7:0] sr_last = 8'h00, sr_val = 8'h00;
  bit m3 = 1'b0, wel_exp = 1'b0, done = 1'b0;
  logic [7:0] dev_mem [int];
  logic [7:0] ref_mem [int];

  always #4 clk = ~clk;

  spi_mem_engine #(.ADDR_W(AW), .ID_LEN(IDN), .ID_VAL(IDV)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_wr_ok(mem_wr_ok), .wel(wel), .sr_rdata(sr_rdata), .sr_wr_ok(sr_wr_ok),
    .sr_wr_stb(sr_wr_stb), .sr_wr_data(sr_wr_data), .sleep(sleep));

  function automatic logic [7:0] seed_byte(int a);
    logic [17:0] x;
    x = 18'(a);
    return x[7:0] ^ x[15:8] ^ {x[17:16], 6'h2B};
  endfunction

  function automatic logic [7:0] ref_byte(int a);
    int w;
    w = a % ASPACE;
    return ref_mem.exists(w) ? ref_mem[w] : seed_byte(w);
  endfunction

  function automatic logic [7:0] id_exp(int i);
    return (i < IDN) ? IDV[(IDN-1-i)*8 +: 8] : 8'h00;
  endfunction

  assign mem_wr_ok = int'(mem_addr) < prot_lo;
  assign sr_rdata = sr_val;

  always @(posedge clk) begin
    if (mem_we) begin
      dev_mem[int'(mem_addr)] = mem_wdata;
      we_cnt++;
    end
    mem_rdata <= dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : seed_byte(int'(mem_addr));
    if (sr_wr_stb) begin
      sr_cnt++;
      sr_last = sr_wr_data;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk);
    sck = m3;
    wait_h();
    cs_n = 1'b0;
    wait_h();
  endtask

  task automatic desel();
    if (!m3) begin
      sck = 1'b0;
      wait_h();
    end
    cs_n = 1'b1;
    wait_h();
    wait_h();
  endtask

  task automatic xb(input logic [7:0] tx, input int nbits, output logic [7:0] rx, output bit oe_all);
    rx = '0;
    oe_all = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si = tx[7-i];
      wait_h();
      rx[7-i] = so;
      oe_all &= so_oe;
      sck = 1'b1;
      wait_h();
    end
  endtask

  task automatic send_addr(int a);
    logic [7:0] r;
    bit oe;
    logic [23:0] w;
    w = {6'($urandom), 18'(a)};
    xb(w[23:16], 8, r, oe);
    xb(w[15:8], 8, r, oe);
    xb(w[7:0], 8, r, oe);
  endtask

  task automatic cmd1(logic [7:0] opc);
    logic [7:0] r;
    bit oe;
    sel();
    xb(opc, 8, r, oe);
    desel();
    if (opc == 8'h06) wel_exp = 1'b1;
    if (opc == 8'h04) wel_exp = 1'b0;
  endtask

  task automatic do_read(bit fast, int a, int n, int si_mode, string req);
    logic [7:0] r, tx;
    bit oe;
    sel();
    xb(fast ? 8'h0B : 8'h03, 8, r, oe);
    send_addr(a);
    if (fast) xb(8'($urandom), 8, r, oe);
    for (int k = 0; k < n; k++) begin
      tx = (si_mode == 0) ? 8'h00 : (si_mode == 1) ? 8'hFF : 8'($urandom);
      xb(tx, 8, r, oe);
      check(r == ref_byte(a + k), req, "read byte", r, ref_byte(a + k));
      check(oe, req, "so_oe during read", oe, 1);
    end
    desel();
  endtask

  task automatic do_write(int a, int n, int tail_bits, string req);
    logic [7:0] r, d;
    bit oe, blocked;
    int cur;
    sel();
    xb(8'h02, 8, r, oe);
    send_addr(a);
    cur = a % ASPACE;
    blocked = 1'b0;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xb(d, 8, r, oe);
      if (wel_exp && !blocked && cur < prot_lo) begin
        ref_mem[cur] = d;
        cur = (cur + 1) % ASPACE;
      end else begin
        blocked = 1'b1;
      end
    end
    if (tail_bits > 0) xb(8'($urandom), tail_bits, r, oe);
    desel();
    wel_exp = 1'b0;
    check(wel == 1'b0, "R7", "wel after write", wel, 0);
  endtask

  task automatic read_out(logic [7:0] opc, int n, output logic [7:0] q [16], output bit oe_all);
    logic [7:0] r;
    bit oe;
    sel();
    xb(opc, 8, r, oe);
    oe_all = 1'b1;
    for (int k = 0; k < n; k++) begin
      xb(8'($urandom), 8, r, oe);
      q[k] = r;
      oe_all &= oe;
    end
    desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] q [16];
    logic [7:0] r;
    bit oe;
    int w0;
    sr_wr_ok = 1'b1;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check(so_oe == 0 && mem_we == 0, "R13", "reset outputs", {so_oe, mem_we}, 0);
    check(wel == 0, "R7", "reset wel", wel, 0);
    check(sleep == 0, "R12", "reset sleep", sleep, 0);

    cmd1(8'h06);
    check(wel == 1, "R7", "wel set", wel, 1);
    cmd1(8'h04);
    check(wel == 0, "R7", "wel cleared", wel, 0);
    sel(); xb(8'h04, 8, r, oe); xb(8'h06, 8, r, oe); desel();
    check(wel == 0, "R1", "second byte not a command", wel, 0);

    do_read(1'b0, 18'h3FFFE, 4, 2, "R3");
    m3 = 1'b1;
    do_read(1'b1, 18'h3FFFD, 5, 2, "R4");
    do_read(1'b0, 18'h01234, 3, 2, "R2");
    m3 = 1'b0;

    cmd1(8'h06);
    w0 = we_cnt;
    do_write(18'h3FFFE, 4, 0, "R5");
    check(we_cnt - w0 == 4, "R5", "write pulses", we_cnt - w0, 4);
    do_read(1'b0, 18'h3FFFE, 4, 2, "R5");

    w0 = we_cnt;
    do_write(18'h00200, 3, 0, "R6");
    check(we_cnt == w0, "R6", "write without wel", we_cnt - w0, 0);

    prot_lo = 18'h00100;
    cmd1(8'h06);
    w0 = we_cnt;
    do_write(18'h000FE, 5, 0, "R6");
    check(we_cnt - w0 == 2, "R6", "burst stops at protected", we_cnt - w0, 2);
    prot_lo = ASPACE;
    do_read(1'b0, 18'h000FD, 6, 2, "R6");

    cmd1(8'h06);
    w0 = we_cnt;
    do_write(18'h00500, 1, 5, "R5");
    check(we_cnt - w0 == 1, "R5", "partial byte dropped", we_cnt - w0, 1);
    do_read(1'b0, 18'h00500, 2, 2, "R5");

    sr_val = 8'h8C;
    read_out(8'h05, 2, q, oe);
    check(q[0] == 8'h8C && q[1] == 8'h8C, "R8", "status bytes", {q[0], q[1]}, 16'h8C8C);
    check(oe, "R8", "status so_oe", oe, 1);

    cmd1(8'h06);
    w0 = sr_cnt;
    sel(); xb(8'h01, 8, r, oe); xb(8'hA5, 8, r, oe); xb(8'h3C, 8, r, oe); desel();
    check(sr_cnt - w0 == 1 && sr_last == 8'hA5, "R9", "status write", sr_last, 8'hA5);
    check(wel == 0, "R7", "wel after status write", wel, 0);
    w0 = sr_cnt;
    sel(); xb(8'h01, 8, r, oe); xb(8'h11, 8, r, oe); desel();
    check(sr_cnt == w0, "R9", "status write without wel", sr_cnt - w0, 0);
    cmd1(8'h06);
    sr_wr_ok = 1'b0;
    sel(); xb(8'h01, 8, r, oe); xb(8'h22, 8, r, oe); desel();
    check(sr_cnt == w0, "R9", "status write refused", sr_cnt - w0, 0);
    sr_wr_ok = 1'b1;
    wel_exp = 1'b0;

    m3 = 1'b1;
    read_out(8'h9F, IDN + 1, q, oe);
    for (int k = 0; k <= IDN; k++)
      check(q[k] == id_exp(k), "R10", "id byte", q[k], id_exp(k));
    m3 = 1'b0;

    cmd1(8'h06);
    w0 = we_cnt;
    sel(); xb(8'h55, 8, r, oe);
    xb(8'h02, 8, r, oe); xb(8'h00, 8, r, oe); xb(8'h00, 8, r, oe); xb(8'h10, 8, r, oe);
    xb(8'hEE, 8, r, oe);
    check(!oe, "R11", "so_oe after unknown", oe, 0);
    desel();
    check(we_cnt == w0 && wel == 1, "R11", "no effect after unknown", {we_cnt - w0, wel}, 1);
    cmd1(8'h04);

    cmd1(8'hB9);
    check(sleep == 1, "R12", "sleep entered", sleep, 1);
    read_out(8'h05, 1, q, oe);
    check(!oe, "R12", "wake transfer ignored", oe, 0);
    check(sleep == 0, "R12", "sleep left", sleep, 0);
    read_out(8'h05, 1, q, oe);
    check(q[0] == 8'h8C && oe, "R12", "after wake", q[0], 8'h8C);

    do_read(1'b0, 18'h00777, 3, 0, "R14");
    do_read(1'b0, 18'h00777, 3, 1, "R14");

    for (int it = 0; it < 40; it++) begin
      int kind, a, n;
      m3 = 1'($urandom);
      kind = $urandom_range(0, 2);
      a = ($urandom_range(0, 3) == 0) ? (ASPACE - $urandom_range(1, 4)) : $urandom_range(0, ASPACE - 1);
      n = $urandom_range(1, 6);
      if (kind == 2) begin
        if ($urandom_range(0, 3) != 0) cmd1(8'h06);
        w0 = we_cnt;
        do_write(a, n, 0, "R5");
        do_read(1'b0, a, n, 2, "R13");
      end else begin
        do_read(kind == 1, a, n, 2, "R13");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule